// File: doc/BRIEF.md
# Registered Twelve-Bit Parity Generator

This block reduces a 12-bit data word to one parity bit. The bit is 1 when an odd number of data bits are set. It is driven straight out on a combinational output, together with its complement. A blanking input forces that output low. Behind the parity output is a one-bit result register, which also has a complemented copy. At each capture, a two-level selector decides what the register takes: its own value (hold), the gated parity bit (load), or a serial input bit (shift). Shift takes priority over hold and load. If each block's register output is wired to the next block's serial input, a chain of these blocks forms a shift path for reading results out.

The whole block runs on one system clock. Capture is triggered by two trigger inputs, which are sampled on that clock. A capture happens in any cycle where at least one of them has risen since the previous sample. A rise on both in the same cycle still gives a single capture. An active-high clear drives the register to 0 at once, without waiting for a clock. The clear is released on the system clock.

Top module: `par12_capture`

## Requirements
- R1: With `blank` at 0, `par` is 1 exactly when an odd number of the 12 bits of `din` are 1. Otherwise it is 0.
- R2: With `blank` at 1, `par` is 0 for every value of `din`.
- R3: `par_n` is always the inverse of `par`, and `y_n` is always the inverse of `y`.
- R4: On a capture with `shift` = 0 and `upd` = 1, `y` takes the value that `par` has in that cycle. The new value is visible after the system clock edge on which the capture occurs.
- R5: On a capture with `shift` = 0 and `upd` = 0, `y` keeps its value.
- R6: On a capture with `shift` = 1, `y` takes `ser_in`, whatever the value of `upd`.
- R7: A capture happens only on a system clock edge where some bit of `trig` is 1 and was 0 at the previous edge. A trigger that stays high, or stays low, leaves `y` unchanged.
- R8: If both trigger bits rise in the same cycle, that cycle makes one capture. It selects the same value as a rise on either bit alone.
- R9: `clr` = 1 forces `y` to 0 at once, without waiting for a clock edge, and overrides a capture in the same cycle. A trigger that is held high through the clear is not a rise. After release, `y` stays 0 until a new rise.
- R10: A load (`shift` = 0, `upd` = 1) while `blank` = 1 stores 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; triggers are sampled on its rising edge |
| clr | input | 1 | Active-high clear of the result register, asynchronous assertion |
| din | input | 12 | Data word whose parity is computed |
| blank | input | 1 | 1 forces `par` to 0 |
| upd | input | 1 | 1 loads parity on capture, 0 holds the register |
| shift | input | 1 | 1 loads `ser_in` on capture, overriding `upd` |
| ser_in | input | 1 | Serial bit for chaining |
| trig | input | 2 | Capture triggers; a rise on either bit causes a capture |
| par | output | 1 | Gated parity, combinational |
| par_n | output | 1 | Inverse of `par` |
| y | output | 1 | Result register |
| y_n | output | 1 | Inverse of `y` |

## Verification
The checker module tests several things on every sampled cycle:
- both complement pairs and the blanking of parity;
- that `y` is 0 while the clear is high;
- that `y` stays unchanged in any cycle without a trigger rise;
- the value stored by a shift, by a hold and by a blanked load.

Other behaviour is only shown by the bench's scenarios:
- the parity of particular data words;
- that a trigger held high through reset is not treated as a rise;
- that the clear acts mid-cycle, before any clock edge;
- that a rise on both triggers together captures the same value as a rise on one.

// File: rtl/par12_pkg.sv
package par12_pkg;

    localparam int DATA_W = 12;
    localparam int TRIG_N = 2;

    // Source that the result register takes on a capture
    typedef enum logic [1:0] {
        SRC_KEEP = 2'd0,
        SRC_PAR  = 2'd1,
        SRC_SER  = 2'd2
    } src_e;

    typedef struct packed {
        logic upd;
        logic shift;
        logic ser;
    } sel_ctrl_t;

    // Shift outranks update; with neither, the register keeps its value
    function automatic src_e pick_src(input sel_ctrl_t c);
        if (c.shift)
            return SRC_SER;
        else if (c.upd)
            return SRC_PAR;
        return SRC_KEEP;
    endfunction

endpackage

// File: rtl/par12_tree.sv
module par12_tree #(
    parameter int W = 12
) (
    input  logic [W-1:0] din,
    input  logic         blank,
    output logic         par
);
    logic [W-1:0] acc;

    assign acc[0] = din[0];

    generate
        for (genvar i = 1; i < W; i++) begin : g_chain
            assign acc[i] = acc[i-1] ^ din[i];
        end
    endgenerate

    assign par = acc[W-1] & ~blank;
endmodule

// File: rtl/par12_trig.sv
module par12_trig #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [N-1:0] trig,
    output logic         fire
);
    logic [N-1:0] prev;
    logic [N-1:0] rise;

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            // Preset to 1 so a trigger held high through clear is not a rise
            always_ff @(posedge clk or posedge clr) begin
                if (clr)
                    prev[i] <= 1'b1;
                else
                    prev[i] <= trig[i];
            end
            assign rise[i] = trig[i] & ~prev[i];
        end
    endgenerate

    assign fire = |rise;
endmodule

// File: rtl/par12_sel.sv
module par12_sel
    import par12_pkg::*;
(
    input  sel_ctrl_t ctrl,
    input  logic      cur,
    input  logic      par,
    output logic      nxt
);
    always_comb begin
        unique case (pick_src(ctrl))
            SRC_SER: nxt = ctrl.ser;
            SRC_PAR: nxt = par;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/par12_capture.sv
module par12_capture
    import par12_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TN = TRIG_N
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [DW-1:0] din,
    input  logic          blank,
    input  logic          upd,
    input  logic          shift,
    input  logic          ser_in,
    input  logic [TN-1:0] trig,
    output logic          par,
    output logic          par_n,
    output logic          y,
    output logic          y_n
);
    logic      par_g;
    logic      fire;
    logic      nxt;
    logic      y_q;
    sel_ctrl_t ctrl;

    par12_tree #(.W(DW)) tree_i (
        .din   (din),
        .blank (blank),
        .par   (par_g)
    );

    par12_trig #(.N(TN)) trig_i (
        .clk  (clk),
        .clr  (clr),
        .trig (trig),
        .fire (fire)
    );

    assign ctrl = '{upd: upd, shift: shift, ser: ser_in};

    par12_sel sel_i (
        .ctrl (ctrl),
        .cur  (y_q),
        .par  (par_g),
        .nxt  (nxt)
    );

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            y_q <= 1'b0;
        else if (fire)
            y_q <= nxt;
    end

    assign par   = par_g;
    assign par_n = ~par_g;
    assign y     = y_q;
    assign y_n   = ~y_q;
endmodule

// File: rtl/par12_capture_chk.sv
module par12_capture_chk #(
    parameter int DW = 12,
    parameter int TN = 2
) (
    input logic          clk,
    input logic          clr,
    input logic [DW-1:0] din,
    input logic          blank,
    input logic          upd,
    input logic          shift,
    input logic          ser_in,
    input logic [TN-1:0] trig,
    input logic          par,
    input logic          par_n,
    input logic          y,
    input logic          y_n
);
    logic [TN-1:0] tq;
    logic          rose;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            tq <= '1;
        else
            tq <= trig;
    end
    assign rose = |(trig & ~tq);

    a_r3_par_pair: assert property (@(posedge clk) par_n == ~par);
    a_r3_y_pair:   assert property (@(posedge clk) y_n == ~y);
    a_r2_blank:    assert property (@(posedge clk) blank |-> !par);
    a_r9_clr_zero: assert property (@(posedge clk) clr |-> !y);

    a_r7_no_rise_stable: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && !$past(rose)) |-> $stable(y));

    a_r6_shift_load: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && $past(rose) && $past(shift)) |-> (y == $past(ser_in)));

    a_r5_hold_keep: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && $past(rose) && !$past(shift) && !$past(upd)) |-> $stable(y));

    a_r10_blank_load: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && $past(rose) && !$past(shift) && $past(upd) && $past(blank)) |-> !y);
endmodule

bind par12_capture par12_capture_chk #(.DW(DW), .TN(TN)) chk_i (
    .clk    (clk),
    .clr    (clr),
    .din    (din),
    .blank  (blank),
    .upd    (upd),
    .shift  (shift),
    .ser_in (ser_in),
    .trig   (trig),
    .par    (par),
    .par_n  (par_n),
    .y      (y),
    .y_n    (y_n)
);

// File: tb/par12_capture_tb.sv
`timescale 1ns/1ps
module par12_capture_tb_top;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        clr;
    logic [11:0] din;
    logic        blank, upd, shift, ser_in;
    logic [1:0]  trig;
    logic        par, par_n, y, y_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    par12_capture dut_i (
        .clk(clk), .clr(clr), .din(din), .blank(blank), .upd(upd),
        .shift(shift), .ser_in(ser_in), .trig(trig),
        .par(par), .par_n(par_n), .y(y), .y_n(y_n)
    );

    // {blank, din, expected par}
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 12'h000, 1'b0}, {1'b0, 12'h001, 1'b1}, {1'b0, 12'h003, 1'b0},
        {1'b0, 12'h007, 1'b1}, {1'b0, 12'hFFF, 1'b0}, {1'b0, 12'h7FF, 1'b1},
        {1'b0, 12'h800, 1'b1}, {1'b0, 12'h555, 1'b0}, {1'b0, 12'hAAB, 1'b1},
        {1'b0, 12'h123, 1'b0}, {1'b1, 12'hFFE, 1'b0}, {1'b1, 12'h001, 1'b0}
    };

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_y(input logic exp, input string req);
        chk(y, exp, req);
        chk(y_n, ~exp, "R3 y_n");
    endtask

    // Rise on mask, capture at the next edge, then return triggers low
    task automatic cap(input logic [1:0] m);
        @(negedge clk) trig = m;
        @(negedge clk) trig = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        clr = 1'b1; din = '0; blank = 0; upd = 0; shift = 0; ser_in = 0;
        trig = 2'b11;
        @(negedge clk); @(negedge clk);
        chk_y(1'b0, "R9 reset value");

        // R1 R2 R3 table walk
        foreach (VEC[i]) begin
            blank = VEC[i][13];
            din   = VEC[i][12:1];
            #1;
            chk(par, VEC[i][0], VEC[i][13] ? "R2 blanked" : "R1 table");
            chk(par_n, ~VEC[i][0], "R3 par_n");
        end
        for (int k = 0; k < 40; k++) begin
            din   = 12'($urandom);
            blank = ($urandom % 4) == 0;
            #1;
            chk(par, blank ? 1'b0 : 1'($countones(din) % 2), "R1 random");
            chk(par_n, ~par, "R3 par_n random");
        end
        blank = 0;

        // R9: trigger held high through clear is no rise
        shift = 1; ser_in = 1;
        @(negedge clk) clr = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk_y(1'b0, "R9 held trigger after release");
        trig = 2'b00;
        @(negedge clk);

        // R4 load
        shift = 0; upd = 1; din = 12'h001;
        cap(2'b01);
        chk_y(1'b1, "R4 load odd");
        // R5 hold
        upd = 0; din = 12'h000;
        cap(2'b10);
        chk_y(1'b1, "R5 hold");
        // R4 load even via other trigger
        upd = 1; din = 12'h003;
        cap(2'b10);
        chk_y(1'b0, "R4 load even");
        // R6 shift with upd low, then with upd high
        shift = 1; ser_in = 1; upd = 0;
        cap(2'b01);
        chk_y(1'b1, "R6 shift in 1");
        upd = 1; din = 12'h001; ser_in = 0;
        cap(2'b10);
        chk_y(1'b0, "R6 shift over load");
        // R8 both rise together
        ser_in = 1;
        cap(2'b11);
        chk_y(1'b1, "R8 dual rise shift");
        shift = 0; upd = 1; din = 12'h000;
        cap(2'b11);
        chk_y(1'b0, "R8 dual rise load");

        // R7: trigger held high, inputs change, no further capture
        shift = 1; ser_in = 1;
        @(negedge clk) trig = 2'b01;
        @(negedge clk);
        chk_y(1'b1, "R7 first rise");
        ser_in = 0;
        @(negedge clk); @(negedge clk);
        chk_y(1'b1, "R7 held high");
        trig = 2'b00; ser_in = 0;
        @(negedge clk); @(negedge clk);
        chk_y(1'b1, "R7 falling edge");

        // R10 blanked load stores 0
        shift = 0; upd = 1; din = 12'h001; blank = 1;
        cap(2'b01);
        chk_y(1'b0, "R10 blanked load");
        blank = 0;
        cap(2'b01);
        chk_y(1'b1, "R4 load after blank");

        // R9 clear asserted together with a capture
        @(negedge clk) begin trig = 2'b01; clr = 1'b1; end
        @(negedge clk);
        chk_y(1'b0, "R9 clear over capture");
        clr = 1'b0; trig = 2'b00;
        @(negedge clk); @(negedge clk);
        chk_y(1'b0, "R9 stays 0 after release");

        // R9 asynchronous action mid-cycle
        cap(2'b10);
        chk_y(1'b1, "R4 reload before async clear");
        @(negedge clk);
        #1 clr = 1'b1;
        #0.5;
        chk_y(1'b0, "R9 async clear");
        @(negedge clk) clr = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule